// File: doc/BRIEF.md
# Zero-Turnaround Synchronous SRAM with Late Write

This block models a single-port synchronous static RAM. Its data bus can carry a read in one cycle and a write in the next, with no idle cycle between them. The address, the read/write select, the byte enables and the chip enables are registered on the rising clock edge. The data for a write is sampled one or two active edges after its command. That gap matches the read latency, so the write-data slot never lands on a slot that a read result occupies. A static mode input selects flow-through reads, where data appears after the command edge and is not registered, or pipelined reads, where data passes through an output register one edge later.

A burst-advance input continues the previous operation at the next address of an aligned four-word group. The group is walked either in linear order or in XOR order, as set by an order-select input. A clock enable freezes every state element. Three chip enables, two active low and one active high, are decoded to one select. An asynchronous output-enable and an asynchronous sleep input gate the output-enable of the data bus. In pipelined mode, a read of a word whose write data arrives on the same edge returns the new bytes.

Top module: `zt_sram`

## Requirements
- R1: With `flow_mode`=1, a read command accepted on an active edge drives `q_oe`=1 and the addressed word on `q_out` from just after that edge until the next active edge.
- R2: With `flow_mode`=0, a read command accepted on active edge n presents its word from just after active edge n+1.
- R3: The write data for a command accepted on active edge n is taken from `d_in` at active edge n+1 when `flow_mode`=1, and at active edge n+2 when `flow_mode`=0.
- R4: A write changes only the 9-bit lanes whose `byte_en` bit was 1 with the command. Bit i of `byte_en` covers `d_in[9i+8:9i]`. An all-zero mask changes nothing.
- R5: A new command is taken only when `chip_sel1_n`=0, `chip_sel2`=1 and `chip_sel3_n`=0. Otherwise the cycle is a deselect, with no write and no read data. A burst advance that follows a deselect is also a deselect.
- R6: `burst_adv`=1 repeats the last read or write at the next address of the aligned group of four. With `linear_order`=1 the low two address bits are (start+k) mod 4; with `linear_order`=0 they are start XOR k. The sequence wraps on the fifth access. The chip enables and `wr` are not used during an advance, but `byte_en` is sampled on each write beat.
- R7: While `clk_en`=0, no command is taken, no write is done, and the outputs hold.
- R8: `oe_n`=1 forces `q_oe`=0 at once, without waiting for a clock.
- R9: `sleep`=1 forces `q_oe`=0 at once. Any command or advance presented while it is high is a deselect. Writes already issued still complete.
- R10: In pipelined mode, a read issued the edge after a write to the same address returns the new data for the enabled bytes and the old data for the others.
- R11: Reads and writes may alternate on every active edge. `q_oe` is 1 only in read-result slots, never in write-data slots.
- R12: After reset, no read or write is pending and `q_oe`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset of the control state |
| clk_en | input | 1 | Clock enable; 0 holds all state |
| chip_sel1_n | input | 1 | Chip enable, active low |
| chip_sel2 | input | 1 | Chip enable, active high |
| chip_sel3_n | input | 1 | Chip enable, active low |
| burst_adv | input | 1 | 1 continues the burst, 0 loads a new command |
| wr | input | 1 | 1 write, 0 read, for a new command |
| byte_en | input | BYTES | Per-lane write enables, active high |
| addr | input | ADDR_W | Word address |
| d_in | input | BYTES*BYTE_W | Write data, sampled late |
| oe_n | input | 1 | Asynchronous output enable, active low |
| sleep | input | 1 | Asynchronous power-down, active high |
| flow_mode | input | 1 | 1 flow-through, 0 pipelined; static between resets |
| linear_order | input | 1 | 1 linear burst order, 0 XOR order |
| q_out | output | BYTES*BYTE_W | Read data |
| q_oe | output | 1 | Read data drive enable for the shared bus |

## Verification
The assertions take `flow_mode` to be static between resets, and the address width to be at least two bits so that a burst group exists. They rely on the clock enable freezing every register, including the burst counter. The bench meets these conditions by changing `flow_mode` and `linear_order` only during reset or between bursts. It drives all inputs half a cycle away from the sampling edge. It reads back only addresses it has written, and it pulses `oe_n` and `sleep` only in whole cycles, so each gating check has a defined expected value.

// File: rtl/zt_sram.sv
module zt_sram #(
  parameter int ADDR_W = 5,
  parameter int BYTES  = 4,
  parameter int BYTE_W = 9
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    clk_en,
  input  logic                    chip_sel1_n,
  input  logic                    chip_sel2,
  input  logic                    chip_sel3_n,
  input  logic                    burst_adv,
  input  logic                    wr,
  input  logic [BYTES-1:0]        byte_en,
  input  logic [ADDR_W-1:0]       addr,
  input  logic [BYTES*BYTE_W-1:0] d_in,
  input  logic                    oe_n,
  input  logic                    sleep,
  input  logic                    flow_mode,
  input  logic                    linear_order,
  output logic [BYTES*BYTE_W-1:0] q_out,
  output logic                    q_oe
);
  localparam int DW    = BYTES * BYTE_W;
  localparam int DEPTH = 1 << ADDR_W;

  typedef enum logic [1:0] {OP_NONE, OP_RD, OP_WR} op_t;

  logic [DW-1:0] mem [DEPTH];

  op_t               s1_op, s2_op, burst_op, nx_op;
  logic [ADDR_W-1:0] s1_addr, s2_addr, burst_base, nx_addr;
  logic [BYTES-1:0]  s1_be, s2_be;
  logic [1:0]        burst_cnt, nx_cnt, nx_low;
  logic [DW-1:0]     out_q, rd_raw, rd_merged;
  logic              out_vld;

  wire selected = !chip_sel1_n && chip_sel2 && !chip_sel3_n;

  always_comb begin
    nx_op   = OP_NONE;
    nx_addr = addr;
    nx_cnt  = burst_cnt;
    nx_low  = linear_order ? burst_base[1:0] + (burst_cnt + 2'd1)
                           : burst_base[1:0] ^ (burst_cnt + 2'd1);
    if (sleep) begin
      nx_op = OP_NONE;
    end else if (burst_adv) begin
      nx_op   = burst_op;
      nx_cnt  = burst_cnt + 2'd1;
      nx_addr = {burst_base[ADDR_W-1:2], nx_low};
    end else if (selected) begin
      nx_op   = wr ? OP_WR : OP_RD;
      nx_cnt  = 2'd0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_op      <= OP_NONE;
      s2_op      <= OP_NONE;
      burst_op   <= OP_NONE;
      burst_cnt  <= 2'd0;
      burst_base <= '0;
      s1_addr    <= '0;
      s2_addr    <= '0;
      s1_be      <= '0;
      s2_be      <= '0;
      out_vld    <= 1'b0;
      out_q      <= '0;
    end else if (clk_en) begin
      s1_op     <= nx_op;
      s1_addr   <= nx_addr;
      s1_be     <= byte_en;
      s2_op     <= s1_op;
      s2_addr   <= s1_addr;
      s2_be     <= s1_be;
      burst_op  <= nx_op;
      burst_cnt <= nx_cnt;
      if (!sleep && !burst_adv) burst_base <= addr;
      out_vld   <= (s1_op == OP_RD);
      out_q     <= rd_merged;
    end
  end

  wire                    w_go   = flow_mode ? (s1_op == OP_WR) : (s2_op == OP_WR);
  wire [ADDR_W-1:0]       w_addr = flow_mode ? s1_addr : s2_addr;
  wire [BYTES-1:0]        w_be   = flow_mode ? s1_be : s2_be;

  always_ff @(posedge clk) begin
    if (clk_en && w_go) begin
      for (int b = 0; b < BYTES; b++) begin
        if (w_be[b]) mem[w_addr][b*BYTE_W +: BYTE_W] <= d_in[b*BYTE_W +: BYTE_W];
      end
    end
  end

  assign rd_raw = mem[s1_addr];

  wire fwd_hit = !flow_mode && (s2_op == OP_WR) && (s2_addr == s1_addr);

  always_comb begin
    rd_merged = rd_raw;
    for (int b = 0; b < BYTES; b++) begin
      if (fwd_hit && s2_be[b]) rd_merged[b*BYTE_W +: BYTE_W] = d_in[b*BYTE_W +: BYTE_W];
    end
  end

  assign q_out = flow_mode ? rd_raw : out_q;
  assign q_oe  = !oe_n && !sleep && (flow_mode ? (s1_op == OP_RD) : out_vld);

  a_r7_hold_freezes: assert property (@(posedge clk) disable iff (!rst_n)
    !clk_en |=> $stable(s1_op) && $stable(s2_op) && $stable(out_vld) && $stable(burst_cnt) && $stable(burst_op));

  a_r2_pipe_result_next: assert property (@(posedge clk) disable iff (!rst_n)
    (clk_en && !flow_mode && s1_op == OP_RD) |=> out_vld);

  a_r5_deselect_empty: assert property (@(posedge clk) disable iff (!rst_n)
    (clk_en && !burst_adv && !selected) |=> s1_op == OP_NONE);

  a_r9_sleep_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    (clk_en && sleep) |=> (s1_op == OP_NONE) && (burst_op == OP_NONE));

  a_r6_burst_wraps: assert property (@(posedge clk) disable iff (!rst_n)
    (clk_en && !sleep && burst_adv && burst_op != OP_NONE && burst_cnt == 2'd3) |=> burst_cnt == 2'd0);

  a_r3_stage_shift: assert property (@(posedge clk) disable iff (!rst_n)
    clk_en |=> s2_op == $past(s1_op));
endmodule

// File: tb/tb_zt_sram.sv
`timescale 1ns/1ps
module tb_zt_sram;
  logic clk = 0, rst_n = 0, clk_en = 1;
  logic chip_sel1_n = 0, chip_sel2 = 1, chip_sel3_n = 0;
  logic burst_adv = 0, wr = 0, oe_n = 0, sleep = 0, flow_mode = 1, linear_order = 1;
  logic [3:0]  byte_en = 0;
  logic [4:0]  addr = 0;
  logic [35:0] d_in = 0;
  logic [35:0] q_out;
  logic        q_oe;

  int errors = 0, checks = 0;

  zt_sram #(.ADDR_W(5), .BYTES(4), .BYTE_W(9)) dut (
    .clk(clk), .rst_n(rst_n), .clk_en(clk_en), .chip_sel1_n(chip_sel1_n),
    .chip_sel2(chip_sel2), .chip_sel3_n(chip_sel3_n), .burst_adv(burst_adv),
    .wr(wr), .byte_en(byte_en), .addr(addr), .d_in(d_in), .oe_n(oe_n),
    .sleep(sleep), .flow_mode(flow_mode), .linear_order(linear_order),
    .q_out(q_out), .q_oe(q_oe));

  always #2.5 clk = ~clk;

  logic [35:0] ref_mem [32];
  int          hop [4];
  logic [4:0]  haddr [4];
  logic [3:0]  hbe [4];
  int          ae = 0, cyc = 0, bop = 0, bk = 0;
  logic [4:0]  bbase = 0;
  logic        exp_vld = 0;
  logic [35:0] exp_dat = 0;

  function automatic logic [35:0] dpat(input int n);
    logic [31:0] h = 32'(n) * 32'h9E3779B1;
    return {4'(n + 3), h};
  endfunction

  task automatic check(input bit cond, input string t, input logic [35:0] act, input logic [35:0] expv);
    checks++;
    if (!cond) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", t, act, expv);
    end
  endtask

  task automatic model_edge();
    int l, j, op;
    logic [4:0] a;
    logic [1:0] low;
    l = flow_mode ? 1 : 2;
    if (ae >= l) begin
      j = (ae - l) % 4;
      if (hop[j] == 2)
        for (int b = 0; b < 4; b++)
          if (hbe[j][b]) ref_mem[haddr[j]][b*9 +: 9] = d_in[b*9 +: 9];
    end
    op = 0; a = addr;
    if (sleep) op = 0;
    else if (burst_adv) begin
      if (bop != 0) begin
        bk = (bk + 1) % 4;
        low = linear_order ? 2'(bbase[1:0] + 2'(bk)) : (bbase[1:0] ^ 2'(bk));
        a = {bbase[4:2], low};
        op = bop;
      end
    end else if (!chip_sel1_n && chip_sel2 && !chip_sel3_n) begin
      op = wr ? 2 : 1; bbase = addr; bk = 0;
    end
    bop = op;
    hop[ae % 4] = op; haddr[ae % 4] = a; hbe[ae % 4] = byte_en;
    l = flow_mode ? 0 : 1;
    exp_vld = 0;
    if (ae >= l) begin
      j = (ae - l) % 4;
      exp_vld = (hop[j] == 1);
      exp_dat = ref_mem[haddr[j]];
    end
    ae++;
  endtask

  task automatic tick(input string t);
    logic eoe;
    d_in = dpat(cyc); cyc++;
    @(posedge clk);
    if (clk_en) model_edge();
    @(negedge clk);
    eoe = exp_vld && !oe_n && !sleep;
    check(q_oe == eoe, {t, " oe"}, 36'(q_oe), 36'(eoe));
    if (eoe) check(q_out == exp_dat, {t, " data"}, q_out, exp_dat);
  endtask

  task automatic sel_ok(); chip_sel1_n = 0; chip_sel2 = 1; chip_sel3_n = 0; endtask
  task automatic wrc(input int a, input logic [3:0] be, input string t);
    sel_ok(); clk_en = 1; burst_adv = 0; wr = 1; addr = 5'(a); byte_en = be; tick(t);
  endtask
  task automatic rd(input int a, input string t);
    sel_ok(); clk_en = 1; burst_adv = 0; wr = 0; addr = 5'(a); byte_en = 0; tick(t);
  endtask
  task automatic brst(input logic [3:0] be, input string t);
    clk_en = 1; burst_adv = 1; byte_en = be; tick(t);
  endtask
  task automatic nop(input string t);
    clk_en = 1; burst_adv = 0; chip_sel2 = 0; tick(t);
  endtask
  task automatic hold(input string t);
    clk_en = 0; tick(t); clk_en = 1;
  endtask

  task automatic do_reset(input logic fm);
    rst_n = 0; flow_mode = fm; clk_en = 1; burst_adv = 0; chip_sel2 = 0;
    ae = 0; bop = 0; bk = 0; exp_vld = 0;
    for (int i = 0; i < 4; i++) hop[i] = 0;
    repeat (2) @(negedge clk);
    check(q_oe == 1'b0, "R12 reset", 36'(q_oe), 36'd0);
    rst_n = 1;
  endtask

  initial begin
    #1_000_000;
    errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    string lat;
    for (int i = 0; i < 32; i++) ref_mem[i] = '0;
    @(negedge clk);
    for (int m = 0; m < 2; m++) begin
      do_reset(m == 0);
      lat = (m == 0) ? "R1" : "R2";
      nop("R12");
      for (int a = 0; a < 32; a++) begin
        wrc(a, 4'hF, "R3");
        if (a > 0) rd(a - 1, "R11");
      end
      nop("R11"); nop("R11");
      for (int a = 0; a < 32; a++) rd(a, lat);
      for (int be = 0; be < 16; be++) begin
        wrc(5, 4'(be), "R4");
        rd(5, "R4");
      end
      wrc(9, 4'hF, "R10"); rd(9, "R10");
      wrc(9, 4'h5, "R10"); rd(9, "R10"); rd(9, "R10");
      for (int lin = 0; lin < 2; lin++) begin
        linear_order = lin[0];
        for (int s = 0; s < 4; s++) begin
          wrc(16 + s, 4'hF, "R6");
          for (int k = 0; k < 3; k++) brst(4'hF, "R6");
          rd(16 + ((s + 1) % 4), "R6");
          for (int k = 0; k < 4; k++) brst(4'h0, "R6");
          wrc(20 + s, 4'hF, "R6");
          brst(4'h3, "R6"); brst(4'hC, "R6");
          rd(20 + s, "R6");
          for (int k = 0; k < 4; k++) brst(4'h0, "R6");
        end
      end
      for (int e = 0; e < 3; e++) begin
        sel_ok(); burst_adv = 0; wr = 1; addr = 5'd3; byte_en = 4'hF;
        if (e == 0) chip_sel1_n = 1;
        if (e == 1) chip_sel2 = 0;
        if (e == 2) chip_sel3_n = 1;
        tick("R5");
        brst(4'hF, "R5");
        rd(3, "R5"); nop("R5"); nop("R5");
      end
      wrc(7, 4'hF, "R7"); hold("R7"); hold("R7");
      nop("R7"); rd(7, "R7"); hold("R7"); hold("R7"); nop("R7"); nop("R7");
      oe_n = 1; rd(7, "R8"); nop("R8"); nop("R8");
      rd(7, "R8"); oe_n = 0; nop("R8"); oe_n = 1; nop("R8"); oe_n = 0; nop("R8");
      sleep = 1; wrc(8, 4'hF, "R9"); brst(4'hF, "R9"); sleep = 0;
      rd(8, "R9"); nop("R9"); nop("R9");
      rd(8, "R9"); sleep = 1; nop("R9"); sleep = 0; nop("R9"); nop("R9");
      for (int a = 0; a < 32; a++) begin
        rd(a, "R11"); wrc((a + 7) % 32, 4'(a), "R11");
      end
      nop("R11"); nop("R11"); nop("R11");
    end
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule